// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the exception control unit that sits beside the execute stage of a small 32-bit processor. It holds three control registers: a status word, a cause word and a saved return address. It watches four event lines: an external interrupt, an instruction fetch fault, an arithmetic overflow and a system call.

When an event is accepted, the block does four things at once. It saves the current program counter, records a 2-bit code for the winning source, and pushes the enable nibble stack in the status word. It then steers the fetch unit to one shared handler address. A return command pops the stack and steers fetch back to the saved address.

Software reads and writes the three registers through a single numbered port. The registers are numbered 12, 13 and 14. The pipeline uses the one-cycle `redirect` pulse together with `next_pc` to flush and refetch.

Top module: `exc_ctrl_unit`

## Requirements
- R1: While `rst` is high at a clock edge, status, cause and saved PC are cleared to zero, `redirect` goes low, and `next_pc` and `cp_rdata` go to zero.
- R2: When any event is accepted at a clock edge, three things happen on that edge. The saved PC takes `cur_pc`. The status word is shifted left by 4 with zero fill. `redirect` is high in the next cycle with `next_pc` equal to `HANDLER_ADDR` (default 0x00000004).
- R3: The cause register holds the accepted source's code in bits [1:0], and reads of it return zero in every higher bit. The codes are: 0 external interrupt, 1 instruction fetch fault, 2 overflow, 3 system call.
- R4: The external interrupt is accepted only if status bit 3 is set. The fetch fault, overflow and system call are accepted regardless of status.
- R5: When several events are eligible in the same cycle, only one is recorded. The order of precedence is fetch fault, then overflow, then system call, then external interrupt.
- R6: A return command that coincides with no accepted event shifts status right by 4 with zero fill. It also produces `redirect` in the next cycle with `next_pc` equal to the saved PC as it was before that edge.
- R7: `cp_rdata` is registered. One cycle after `cp_addr` holds 12, 13 or 14, it shows status, cause or saved PC as they were before that edge. Any other register number reads as zero.
- R8: A write with `cp_we` high updates the numbered register at the next edge. Cause keeps only data bits [1:0]. An accepted event in the same cycle overrides the write to every register. A return in the same cycle overrides only a status write.
- R9: `redirect` is high only in the cycle after an accepted event or a return. `next_pc` holds its value whenever `redirect` is low.
- R10: An accepted event and a return command in the same cycle act as the event alone. The status word is pushed, not popped, and `next_pc` is the handler address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_int | input | 1 | External interrupt request (maskable) |
| ev_ibus | input | 1 | Instruction fetch fault |
| ev_ovf | input | 1 | Arithmetic overflow |
| ev_sys | input | 1 | System call |
| cur_pc | input | DATA_W | Address saved on event entry |
| ret_cmd | input | 1 | Return-from-exception command |
| cp_addr | input | 5 | Register number for read and write |
| cp_we | input | 1 | Write strobe for the numbered register |
| cp_wdata | input | DATA_W | Write data |
| cp_rdata | output | DATA_W | Registered read data |
| next_pc | output | DATA_W | Fetch target that accompanies `redirect` |
| redirect | output | 1 | One-cycle fetch steering pulse |

## Verification
The bench builds the block with its default values: a 32-bit data path and handler address 0x4. With these values the status word holds eight 4-bit enable groups, so nested entries, returns and shifts that push a set enable bit off either end all fall within reach. Directed sequences cover masked and unmasked interrupts, every collision between events, returns and register writes, and unmapped register numbers. A long stretch of random traffic then mixes all inputs while a behavioural model is compared with the outputs on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int CODE_W   = 2;
  localparam int GRP_W    = 4;
  localparam int REGNUM_W = 5;
  localparam int NUM_SRC  = 4;

  typedef enum logic [CODE_W-1:0] {
    EXC_INT  = 2'd0,
    EXC_IBUS = 2'd1,
    EXC_OVF  = 2'd2,
    EXC_SYS  = 2'd3
  } exc_code_e;

  localparam logic [REGNUM_W-1:0] RN_STATUS = 5'd12;
  localparam logic [REGNUM_W-1:0] RN_CAUSE  = 5'd13;
  localparam logic [REGNUM_W-1:0] RN_EPC    = 5'd14;

  // Enable bit of a source inside one status group: code 0 -> bit 3 ... code 3 -> bit 0
  function automatic int unsigned en_bit(exc_code_e c);
    return GRP_W - 1 - int'(c);
  endfunction

endpackage

// File: rtl/exc_event_sel.sv
module exc_event_sel
  import exc_pkg::*;
(
  input  logic              ev_int,
  input  logic              ev_ibus,
  input  logic              ev_ovf,
  input  logic              ev_sys,
  input  logic [GRP_W-1:0]  en_grp,
  output logic              take,
  output exc_code_e         code
);

  // Highest precedence first
  localparam exc_code_e PRIO [NUM_SRC] = '{EXC_IBUS, EXC_OVF, EXC_SYS, EXC_INT};

  logic [NUM_SRC-1:0] elig;

  always_comb begin
    elig                 = '0;
    elig[int'(EXC_INT)]  = ev_int & en_grp[en_bit(EXC_INT)];
    elig[int'(EXC_IBUS)] = ev_ibus;
    elig[int'(EXC_OVF)]  = ev_ovf;
    elig[int'(EXC_SYS)]  = ev_sys;
  end

  always_comb begin
    take = 1'b0;
    code = EXC_INT;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[int'(PRIO[i])]) begin
        take = 1'b1;
        code = PRIO[i];
      end
    end
  end

endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
  import exc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  exc_code_e           code,
  input  logic [DATA_W-1:0]   cur_pc,
  input  logic                ret,
  input  logic                we,
  input  logic [REGNUM_W-1:0] waddr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   status_q,
  output logic [CODE_W-1:0]   cause_q,
  output logic [DATA_W-1:0]   epc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      cause_q  <= '0;
      epc_q    <= '0;
    end else if (take) begin
      status_q <= status_q << GRP_W;
      cause_q  <= code;
      epc_q    <= cur_pc;
    end else begin
      if (we) begin
        case (waddr)
          RN_STATUS: status_q <= wdata;
          RN_CAUSE:  cause_q  <= wdata[CODE_W-1:0];
          RN_EPC:    epc_q    <= wdata;
          default:   ;
        endcase
      end
      // later assignment wins over a same-cycle status write
      if (ret) status_q <= status_q >> GRP_W;
    end
  end

endmodule

// File: rtl/exc_redirect.sv
module exc_redirect #(
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              ret,
  input  logic [DATA_W-1:0] epc_q,
  output logic              redirect,
  output logic [DATA_W-1:0] next_pc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect <= 1'b0;
      next_pc  <= '0;
    end else begin
      redirect <= take | ret;
      if (take)     next_pc <= HANDLER_ADDR;
      else if (ret) next_pc <= epc_q;
    end
  end

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 'h4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_int,
  input  logic                ev_ibus,
  input  logic                ev_ovf,
  input  logic                ev_sys,
  input  logic [DATA_W-1:0]   cur_pc,
  input  logic                ret_cmd,
  input  logic [REGNUM_W-1:0] cp_addr,
  input  logic                cp_we,
  input  logic [DATA_W-1:0]   cp_wdata,
  output logic [DATA_W-1:0]   cp_rdata,
  output logic [DATA_W-1:0]   next_pc,
  output logic                redirect
);

  logic              take;
  exc_code_e         code;
  logic [DATA_W-1:0] status_q;
  logic [CODE_W-1:0] cause_q;
  logic [DATA_W-1:0] epc_q;

  exc_event_sel u_sel (
    .ev_int  (ev_int),
    .ev_ibus (ev_ibus),
    .ev_ovf  (ev_ovf),
    .ev_sys  (ev_sys),
    .en_grp  (status_q[GRP_W-1:0]),
    .take    (take),
    .code    (code)
  );

  exc_csr_bank #(.DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .code     (code),
    .cur_pc   (cur_pc),
    .ret      (ret_cmd),
    .we       (cp_we),
    .waddr    (cp_addr),
    .wdata    (cp_wdata),
    .status_q (status_q),
    .cause_q  (cause_q),
    .epc_q    (epc_q)
  );

  exc_redirect #(.DATA_W(DATA_W), .HANDLER_ADDR(HANDLER_ADDR)) u_redir (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .ret      (ret_cmd),
    .epc_q    (epc_q),
    .redirect (redirect),
    .next_pc  (next_pc)
  );

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      cp_rdata <= '0;
    end else begin
      case (cp_addr)
        RN_STATUS: cp_rdata <= status_q;
        RN_CAUSE:  cp_rdata <= {{(DATA_W-CODE_W){1'b0}}, cause_q};
        RN_EPC:    cp_rdata <= epc_q;
        default:   cp_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/exc_ctrl_unit_chk.sv
module exc_ctrl_unit_chk
  import exc_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 'h4
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_int,
  input logic              ev_ibus,
  input logic              ev_ovf,
  input logic              ev_sys,
  input logic [DATA_W-1:0] cur_pc,
  input logic              ret_cmd,
  input logic [DATA_W-1:0] status_q,
  input logic [CODE_W-1:0] cause_q,
  input logic [DATA_W-1:0] epc_q,
  input logic [DATA_W-1:0] next_pc,
  input logic              redirect
);

  logic sync_ev;
  assign sync_ev = ev_ibus | ev_ovf | ev_sys;

  assert_sync_entry_R2: assert property (@(posedge clk) disable iff (rst)
    sync_ev |=> redirect && next_pc == HANDLER_ADDR && epc_q == $past(cur_pc)
                && status_q == ($past(status_q) << GRP_W));

  assert_masked_int_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_int && !status_q[GRP_W-1] && !sync_ev && !ret_cmd) |=> !redirect);

  assert_ibus_first_R5: assert property (@(posedge clk) disable iff (rst)
    ev_ibus |=> cause_q == 2'd1);

  assert_ovf_second_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_ovf && !ev_ibus) |=> cause_q == 2'd2);

  assert_return_R6: assert property (@(posedge clk) disable iff (rst)
    (ret_cmd && !sync_ev && !(ev_int && status_q[GRP_W-1]))
      |=> redirect && next_pc == $past(epc_q) && status_q == ($past(status_q) >> GRP_W));

  assert_hold_pc_R9: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> $stable(next_pc));

  assert_entry_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (ret_cmd && sync_ev) |=> next_pc == HANDLER_ADDR);

endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk #(.DATA_W(DATA_W), .HANDLER_ADDR(HANDLER_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_int   (ev_int),
  .ev_ibus  (ev_ibus),
  .ev_ovf   (ev_ovf),
  .ev_sys   (ev_sys),
  .cur_pc   (cur_pc),
  .ret_cmd  (ret_cmd),
  .status_q (status_q),
  .cause_q  (cause_q),
  .epc_q    (epc_q),
  .next_pc  (next_pc),
  .redirect (redirect)
);

// File: tb/sim_exc_ctrl_unit.sv
module sim_exc_ctrl_unit;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_int = 0, ev_ibus = 0, ev_ovf = 0, ev_sys = 0, ret_cmd = 0, cp_we = 0;
  logic [DW-1:0] cur_pc = '0, cp_wdata = '0;
  logic [4:0]    cp_addr = '0;
  logic [DW-1:0] cp_rdata, next_pc;
  logic          redirect;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  exc_ctrl_unit u0 (
    .clk(clk), .rst(rst), .ev_int(ev_int), .ev_ibus(ev_ibus), .ev_ovf(ev_ovf),
    .ev_sys(ev_sys), .cur_pc(cur_pc), .ret_cmd(ret_cmd), .cp_addr(cp_addr),
    .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .next_pc(next_pc),
    .redirect(redirect)
  );

  // Behavioural reference model
  logic [31:0] m_status, m_epc, m_npc, m_rdata;
  logic [1:0]  m_cause;
  logic        m_redir;

  always @(posedge clk) begin : model
    logic [31:0] os, oe;
    logic        tk;
    logic [1:0]  cd;
    if (rst) begin
      m_status = 0; m_epc = 0; m_npc = 0; m_rdata = 0; m_cause = 0; m_redir = 0;
    end else begin
      os = m_status; oe = m_epc;
      if (cp_addr == 12)      m_rdata = os;
      else if (cp_addr == 13) m_rdata = {30'd0, m_cause};
      else if (cp_addr == 14) m_rdata = oe;
      else                    m_rdata = 0;
      tk = 1'b1; cd = 2'd0;
      if (ev_ibus)                cd = 2'd1;
      else if (ev_ovf)            cd = 2'd2;
      else if (ev_sys)            cd = 2'd3;
      else if (ev_int && os[3])   cd = 2'd0;
      else                        tk = 1'b0;
      if (cp_we) begin
        if (cp_addr == 12) m_status = cp_wdata;
        if (cp_addr == 13) m_cause  = cp_wdata[1:0];
        if (cp_addr == 14) m_epc    = cp_wdata;
      end
      if (ret_cmd) m_status = os >> 4;
      if (tk) begin m_status = os << 4; m_cause = cd; m_epc = cur_pc; end
      m_redir = tk || ret_cmd;
      if (tk)           m_npc = 32'h4;
      else if (ret_cmd) m_npc = oe;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(cur_req, "redirect", {31'd0, redirect}, {31'd0, m_redir});
    check(cur_req, "next_pc", next_pc, m_npc);
    check(cur_req, "cp_rdata", cp_rdata, m_rdata);
  endtask

  task automatic clear_in();
    ev_int = 0; ev_ibus = 0; ev_ovf = 0; ev_sys = 0; ret_cmd = 0; cp_we = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string req);
    clear_in(); cp_addr = a; tick();
    check(req, "read", cp_rdata, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    clear_in(); cp_addr = a; cp_we = 1; cp_wdata = d; tick(); cp_we = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    cur_req = "R1";
    check("R1", "redirect", {31'd0, redirect}, 0);
    rd(12, 0, "R1"); rd(13, 0, "R1"); rd(14, 0, "R1");

    // R4 masked interrupt
    cur_req = "R4";
    ev_int = 1; cur_pc = 32'h40; tick(); ev_int = 0;
    check("R4", "masked redirect", {31'd0, redirect}, 0);
    // R8 write enables INT
    cur_req = "R8";
    wr(12, 32'h8); rd(12, 32'h8, "R8");
    cur_req = "R4";
    ev_int = 1; cur_pc = 32'h100; tick(); ev_int = 0;
    check("R4", "int redirect", {31'd0, redirect}, 1);
    check("R2", "handler", next_pc, 32'h4);
    rd(13, 0, "R3"); rd(14, 32'h100, "R2"); rd(12, 32'h80, "R2");

    // R6 return
    cur_req = "R6";
    clear_in(); ret_cmd = 1; tick(); ret_cmd = 0;
    check("R6", "return pc", next_pc, 32'h100);
    rd(12, 32'h8, "R6");

    // R2 / R3 each synchronous source
    cur_req = "R3";
    for (int i = 0; i < 3; i++) begin
      clear_in(); cur_pc = 32'h200 + i * 4;
      if (i == 0) ev_ibus = 1; else if (i == 1) ev_ovf = 1; else ev_sys = 1;
      tick(); clear_in();
      check("R2", "sync redirect", {31'd0, redirect}, 1);
      check("R2", "sync handler", next_pc, 32'h4);
      tick();
      check("R9", "pulse end", {31'd0, redirect}, 0);
      rd(13, i + 1, "R3");
    end
    rd(12, 32'h8000, "R2");

    // R6 nested returns
    cur_req = "R6";
    for (int i = 0; i < 3; i++) begin
      clear_in(); ret_cmd = 1; tick(); ret_cmd = 0;
      check("R6", "nested return pc", next_pc, 32'h208);
    end
    rd(12, 32'h8, "R6");

    // R5 priority
    cur_req = "R5";
    ev_ibus = 1; ev_ovf = 1; ev_sys = 1; ev_int = 1; tick(); rd(13, 1, "R5");
    ev_ovf = 1; ev_sys = 1; ev_int = 1; tick(); rd(13, 2, "R5");
    ev_sys = 1; ev_int = 1; tick(); rd(13, 3, "R5");
    rd(12, 32'h8000, "R5");

    // R8 collisions
    cur_req = "R8";
    clear_in(); cp_addr = 14; cp_we = 1; cp_wdata = 32'hDEAD; ev_sys = 1; cur_pc = 32'h300;
    tick(); rd(14, 32'h300, "R8");
    clear_in(); cp_addr = 12; cp_we = 1; cp_wdata = 32'hFFFF; ret_cmd = 1;
    tick(); rd(12, 32'h8000, "R8");
    clear_in(); cp_addr = 14; cp_we = 1; cp_wdata = 32'h444; ret_cmd = 1;
    tick(); check("R8", "ret uses old epc", next_pc, 32'h300);
    rd(14, 32'h444, "R8"); rd(12, 32'h800, "R8");
    wr(13, 32'hFFFF_FFFE); rd(13, 2, "R8");

    // R10 entry beats return
    cur_req = "R10";
    wr(12, 32'h8);
    clear_in(); ev_ovf = 1; ret_cmd = 1; cur_pc = 32'h500; tick(); clear_in();
    check("R10", "handler", next_pc, 32'h4);
    rd(12, 32'h80, "R10"); rd(13, 2, "R10"); rd(14, 32'h500, "R10");

    // R7 unmapped numbers
    cur_req = "R7";
    rd(5, 0, "R7"); rd(15, 0, "R7"); rd(0, 0, "R7");

    // R9 random traffic
    cur_req = "R9";
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      ev_int  = ($urandom % 4) == 0;
      ev_ibus = ($urandom % 16) == 0;
      ev_ovf  = ($urandom % 16) == 0;
      ev_sys  = ($urandom % 12) == 0;
      ret_cmd = ($urandom % 6) == 0;
      cp_we   = ($urandom % 5) == 0;
      cp_addr = 5'(10 + (r % 6));
      cp_wdata = ($urandom % 2) ? 32'($urandom) : 32'h8888_8888;
      cur_pc  = 32'($urandom) & 32'hFFFF_FFFC;
      tick();
    end
    clear_in(); tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule